// File: doc/BRIEF.md
# Program Memory Programming and Lock Controller

This block manages the on-chip program store of a small microcontroller while it is in its programming fixture. Six static control pins choose one of six operations: read a fixed identification byte, write a code byte, read back a code byte, write an entry of a 32-entry scramble key table, or set one of two protection bits. A write is committed only after the programming strobe input has been pulsed low a fixed number of times (25 by default). The block holds the code array, the key table and the two protection bits as register arrays.

Read-back is scrambled. The returned byte is the bitwise XNOR of the stored code byte with the key entry picked by the low five address bits. An erased key entry is all ones, so an unprogrammed table returns plain data. The key table cannot be read on its own. Protection is staged. Setting either protection bit blocks further code and key writes but still allows the other bit to be set. Protection bit 1 makes the external-access strap level sampled at reset the one that counts, and blocks reads of internal memory by code running from external memory. With both bits set, read-back is blocked.

Top module: `pmem_prog_ctrl`

## Requirements
- R1: The mode pins `ctl_pins[5:0]` are decoded as follows: bit 5 must be 1 and bit 4 must be 0, and bits 3:0 select the mode. The codes are 0000 signature, 1011 write code, 0011 read back, 1010 write key, 1111 set protection 1 and 1100 set protection 2. Any other pattern is idle: no write is made and `dout` is FFh.
- R2: In a write mode, a write is made on the 25th falling edge of `prog_n` counted since the mode was entered. The matching write-enable output is then high for exactly one cycle. After 24 edges no write is made.
- R3: In read-back mode, `dout` equals XNOR(code[addr], key[addr[4:0]]), two clock edges after the address and mode are applied.
- R4: Code and key locations that were never written hold FFh. An unwritten code location therefore reads back as FFh.
- R5: A key write takes effect only when `addr` is below 020h. A key write at a higher address leaves the table unchanged and `key_we` stays low.
- R6: In signature mode, address 030h returns 89h, address 031h returns 57h and every other address returns FFh.
- R7: Once either protection bit is set, code and key writes are rejected (`code_we` and `key_we` stay low). Both protection bits can still be set, and a set bit stays set.
- R8: With both protection bits set, read-back returns FFh. Signature read is not affected. With only protection bit 1 set, read-back still works.
- R9: `int_fetch_deny` is 1 when protection bit 1 is set and the effective external-access level is 0.
- R10: `ea_eff` follows `ea_pin` with one cycle of delay while protection bit 1 is clear. Once the bit is set, `ea_eff` shows the `ea_pin` level sampled during the last reset and ignores later pin changes.
- R11: If reset is high in the cycle where the 25th strobe edge is detected, reset wins. No write is made and the pulse count restarts.
- R12: Leaving a write mode, even for a single cycle, clears the pulse count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_pins | input | 6 | Mode select pins |
| addr | input | ADDR_W | Code, key or signature address |
| din | input | DATA_W | Byte to be written |
| prog_n | input | 1 | Programming strobe, active low |
| ea_pin | input | 1 | External-access strap level |
| dout | output | DATA_W | Read-back or signature byte |
| code_we | output | 1 | Code array write pulse |
| key_we | output | 1 | Key table write pulse |
| lock1_we | output | 1 | Protection bit 1 set pulse |
| lock2_we | output | 1 | Protection bit 2 set pulse |
| ea_eff | output | 1 | Effective external-access level |
| int_fetch_deny | output | 1 | Internal memory read blocked for external code |

## Verification
Two events can fall in the same cycle: reset and the commit of the 25th strobe edge. The bench drives 24 full pulses, pulls the strobe low, and raises reset exactly for the edge at which the falling edge is recognised. The check passes if no write-enable pulse appears and the addressed byte still reads back as erased. A second collision is a mode change between pulses. That is judged by the exact number of further pulses needed before the write lands.

// File: rtl/pmem_pkg.sv
package pmem_pkg;

  typedef enum logic [2:0] {
    M_IDLE,
    M_SIG,
    M_PCODE,
    M_VERIFY,
    M_PKEY,
    M_PLK1,
    M_PLK2
  } pmode_t;

  localparam logic [5:0] PIN_SIG    = 6'b10_0000;
  localparam logic [5:0] PIN_PCODE  = 6'b10_1011;
  localparam logic [5:0] PIN_VERIFY = 6'b10_0011;
  localparam logic [5:0] PIN_PKEY   = 6'b10_1010;
  localparam logic [5:0] PIN_PLK1   = 6'b10_1111;
  localparam logic [5:0] PIN_PLK2   = 6'b10_1100;

  function automatic pmode_t pin_decode(input logic [5:0] p);
    pmode_t m;
    case (p)
      PIN_SIG:    m = M_SIG;
      PIN_PCODE:  m = M_PCODE;
      PIN_VERIFY: m = M_VERIFY;
      PIN_PKEY:   m = M_PKEY;
      PIN_PLK1:   m = M_PLK1;
      PIN_PLK2:   m = M_PLK2;
      default:    m = M_IDLE;
    endcase
    return m;
  endfunction

  function automatic logic is_write_mode(input pmode_t m);
    return (m == M_PCODE) || (m == M_PKEY) || (m == M_PLK1) || (m == M_PLK2);
  endfunction

endpackage

// File: rtl/pmem_mode_dec.sv
module pmem_mode_dec
  import pmem_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] pins_i,
  output pmode_t     mode_o,
  output logic       wr_mode_o,
  output logic       mode_chg_o
);

  pmode_t mode_q, mode_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= M_IDLE;
      mode_prev <= M_IDLE;
    end else begin
      mode_q    <= pin_decode(pins_i);
      mode_prev <= mode_q;
    end
  end

  assign mode_o     = mode_q;
  assign wr_mode_o  = is_write_mode(mode_q);
  assign mode_chg_o = (mode_q != mode_prev);

  p_idle_after_reset_r1: assert property (@(posedge clk)
    rst |=> (mode_q == M_IDLE));

endmodule

// File: rtl/pmem_pulse_cnt.sv
module pmem_pulse_cnt #(
  parameter int PULSES = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic prog_n,
  input  logic wr_mode_i,
  input  logic mode_chg_i,
  output logic commit_o
);

  localparam int CW = $clog2(PULSES + 1);
  localparam logic [CW-1:0] LAST = CW'(PULSES - 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;
  logic          fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= prog_n;
      s2 <= s1;
    end
  end

  assign fall = s2 & ~s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!wr_mode_i || mode_chg_i) begin
      cnt <= '0;
    end else if (fall) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  assign commit_o = wr_mode_i & ~mode_chg_i & fall & (cnt == LAST);

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(PULSES));
  p_idle_clears_r12: assert property (@(posedge clk) disable iff (rst)
    !wr_mode_i |=> (cnt == '0));
  p_reset_clears_r11: assert property (@(posedge clk)
    rst |=> (cnt == '0));

endmodule

// File: rtl/pmem_store.sv
module pmem_store
  import pmem_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int KEY_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_i,
  input  pmode_t            mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] code_q_o,
  output logic [DATA_W-1:0] key_q_o,
  output logic              lock1_o,
  output logic              lock2_o,
  output logic              code_we_o,
  output logic              key_we_o,
  output logic              lk1_we_o,
  output logic              lk2_we_o
);

  localparam int CODE_DEPTH = 1 << ADDR_W;
  localparam int KW         = $clog2(KEY_DEPTH);

  logic [DATA_W-1:0] code_mem [CODE_DEPTH];
  logic [DATA_W-1:0] key_mem  [KEY_DEPTH];
  logic              lock1_r = 1'b0;
  logic              lock2_r = 1'b0;

  logic locked, go, code_wr, key_wr, lk1_wr, lk2_wr, key_in_range;

  initial begin
    for (int i = 0; i < CODE_DEPTH; i++) code_mem[i] = '1;
    for (int j = 0; j < KEY_DEPTH; j++)  key_mem[j]  = '1;
  end

  assign locked       = lock1_r | lock2_r;
  assign go           = commit_i & ~rst;
  assign key_in_range = (addr_i[ADDR_W-1:KW] == '0);
  assign code_wr      = go & (mode_i == M_PCODE) & ~locked;
  assign key_wr       = go & (mode_i == M_PKEY) & ~locked & key_in_range;
  assign lk1_wr       = go & (mode_i == M_PLK1);
  assign lk2_wr       = go & (mode_i == M_PLK2);

  always_ff @(posedge clk) begin
    if (code_wr) code_mem[addr_i] <= din_i;
    code_q_o <= code_mem[addr_i];
  end

  always_ff @(posedge clk) begin
    if (key_wr) key_mem[addr_i[KW-1:0]] <= din_i;
    key_q_o <= key_mem[addr_i[KW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (lk1_wr) lock1_r <= 1'b1;
    if (lk2_wr) lock2_r <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_we_o <= 1'b0;
      key_we_o  <= 1'b0;
      lk1_we_o  <= 1'b0;
      lk2_we_o  <= 1'b0;
    end else begin
      code_we_o <= code_wr;
      key_we_o  <= key_wr;
      lk1_we_o  <= lk1_wr;
      lk2_we_o  <= lk2_wr;
    end
  end

  assign lock1_o = lock1_r;
  assign lock2_o = lock2_r;

  p_lock_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    (lock1_o || lock2_o) |=> (!code_we_o && !key_we_o));
  p_lock1_sticky_r7: assert property (@(posedge clk)
    lock1_o |=> lock1_o);
  p_lock2_sticky_r7: assert property (@(posedge clk)
    lock2_o |=> lock2_o);
  p_reset_no_write_r11: assert property (@(posedge clk)
    rst |=> (!code_we_o && !key_we_o && !lk1_we_o && !lk2_we_o));
  p_we_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({code_we_o, key_we_o, lk1_we_o, lk2_we_o}));

endmodule

// File: rtl/pmem_readout.sv
module pmem_readout
  import pmem_pkg::*;
#(
  parameter int                ADDR_W   = 12,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] SIG_BASE = 12'h030,
  parameter logic [DATA_W-1:0] SIG_B0   = 8'h89,
  parameter logic [DATA_W-1:0] SIG_B1   = 8'h57
) (
  input  logic              clk,
  input  logic              rst,
  input  pmode_t            mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] code_q_i,
  input  logic [DATA_W-1:0] key_q_i,
  input  logic              lock1_i,
  input  logic              lock2_i,
  output logic [DATA_W-1:0] dout_o
);

  localparam logic [ADDR_W-1:0] SIG_NEXT = SIG_BASE + 1'b1;

  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] nxt;

  always_ff @(posedge clk) begin
    if (rst) addr_d <= '0;
    else     addr_d <= addr_i;
  end

  always_comb begin
    nxt = '1;
    case (mode_i)
      M_SIG: begin
        if (addr_d == SIG_BASE)      nxt = SIG_B0;
        else if (addr_d == SIG_NEXT) nxt = SIG_B1;
      end
      M_VERIFY: begin
        if (!(lock1_i && lock2_i)) nxt = ~(code_q_i ^ key_q_i);
      end
      default: nxt = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) dout_o <= '1;
    else     dout_o <= nxt;
  end

  p_both_locks_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_i == M_VERIFY && lock1_i && lock2_i) |=> (dout_o == '1));
  p_sig_first_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_i == M_SIG && addr_d == SIG_BASE) |=> (dout_o == SIG_B0));
  p_idle_ff_r1: assert property (@(posedge clk) disable iff (rst)
    (mode_i == M_IDLE) |=> (dout_o == '1));

endmodule

// File: rtl/pmem_prog_ctrl.sv
module pmem_prog_ctrl
  import pmem_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter int                DATA_W    = 8,
  parameter int                KEY_DEPTH = 32,
  parameter int                PULSES    = 25,
  parameter logic [ADDR_W-1:0] SIG_BASE  = 12'h030,
  parameter logic [DATA_W-1:0] SIG_B0    = 8'h89,
  parameter logic [DATA_W-1:0] SIG_B1    = 8'h57
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [5:0]        ctl_pins,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              prog_n,
  input  logic              ea_pin,
  output logic [DATA_W-1:0] dout,
  output logic              code_we,
  output logic              key_we,
  output logic              lock1_we,
  output logic              lock2_we,
  output logic              ea_eff,
  output logic              int_fetch_deny
);

  pmode_t            mode;
  logic              wr_mode, mode_chg, commit;
  logic [DATA_W-1:0] code_q, key_q;
  logic              lock1, lock2;
  logic              ea_hold;

  pmem_mode_dec u_dec (
    .clk(clk), .rst(rst), .pins_i(ctl_pins),
    .mode_o(mode), .wr_mode_o(wr_mode), .mode_chg_o(mode_chg)
  );

  pmem_pulse_cnt #(.PULSES(PULSES)) u_cnt (
    .clk(clk), .rst(rst), .prog_n(prog_n),
    .wr_mode_i(wr_mode), .mode_chg_i(mode_chg), .commit_o(commit)
  );

  pmem_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_DEPTH(KEY_DEPTH)) u_store (
    .clk(clk), .rst(rst), .commit_i(commit), .mode_i(mode),
    .addr_i(addr), .din_i(din),
    .code_q_o(code_q), .key_q_o(key_q),
    .lock1_o(lock1), .lock2_o(lock2),
    .code_we_o(code_we), .key_we_o(key_we),
    .lk1_we_o(lock1_we), .lk2_we_o(lock2_we)
  );

  pmem_readout #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SIG_BASE(SIG_BASE), .SIG_B0(SIG_B0), .SIG_B1(SIG_B1)
  ) u_rd (
    .clk(clk), .rst(rst), .mode_i(mode), .addr_i(addr),
    .code_q_i(code_q), .key_q_i(key_q),
    .lock1_i(lock1), .lock2_i(lock2), .dout_o(dout)
  );

  always_ff @(posedge clk) begin
    if (rst) ea_hold <= ea_pin;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_eff         <= ea_pin;
      int_fetch_deny <= 1'b0;
    end else begin
      ea_eff         <= lock1 ? ea_hold : ea_pin;
      int_fetch_deny <= lock1 & ~ea_hold;
    end
  end

  p_ea_held_r10: assert property (@(posedge clk) disable iff (rst)
    lock1 |=> $stable(ea_hold));
  p_no_deny_unlocked_r9: assert property (@(posedge clk) disable iff (rst)
    (!lock1 && !$past(lock1)) |-> !int_fetch_deny);

endmodule

// File: tb/pmem_prog_ctrl_test.sv
module pmem_prog_ctrl_test;
  import pmem_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] PIN_IDLE = 6'b10_0101;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] ctl_pins = PIN_IDLE;
  logic [11:0] addr = '0;
  logic [7:0] din = '0;
  logic       prog_n = 1'b1;
  logic       ea_pin = 1'b1;
  logic [7:0] dout;
  logic       code_we, key_we, lock1_we, lock2_we, ea_eff, int_fetch_deny;

  int n_chk = 0, n_bad = 0;
  int n_code = 0, n_key = 0, n_l1 = 0, n_l2 = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmem_prog_ctrl uut (
    .clk(clk), .rst(rst), .ctl_pins(ctl_pins), .addr(addr), .din(din),
    .prog_n(prog_n), .ea_pin(ea_pin), .dout(dout),
    .code_we(code_we), .key_we(key_we), .lock1_we(lock1_we), .lock2_we(lock2_we),
    .ea_eff(ea_eff), .int_fetch_deny(int_fetch_deny)
  );

  always @(negedge clk) begin
    if (code_we)  n_code++;
    if (key_we)   n_key++;
    if (lock1_we) n_l1++;
    if (lock2_we) n_l2++;
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_mode(logic [5:0] p);
    @(negedge clk) ctl_pins = p;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) prog_n = 1'b0;
      @(negedge clk);
      @(negedge clk) prog_n = 1'b1;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic do_write(logic [5:0] p, logic [11:0] a, logic [7:0] d, int n);
    addr = a; din = d;
    set_mode(p);
    pulses(n);
    set_mode(PIN_IDLE);
  endtask

  task automatic read_at(logic [5:0] p, logic [11:0] a, output logic [7:0] v);
    @(negedge clk) begin ctl_pins = p; addr = a; end
    repeat (3) @(negedge clk);
    v = dout;
  endtask

  task automatic pulse_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 reset dout", dout, 8'hFF);
    chk("R1 reset code_we", code_we, 0);
    chk("R9 reset deny", int_fetch_deny, 0);
    chk("R10 reset ea_eff", ea_eff, 1);
    read_at(PIN_VERIFY, 12'h123, v);
    chk("R4 erased reads FF", v, 8'hFF);
  endtask

  task automatic t_code_write();
    logic [7:0] v;
    int c0 = n_code;
    do_write(PIN_PCODE, 12'h123, 8'hA5, 25);
    chk("R2 one code_we pulse", n_code - c0, 1);
    read_at(PIN_VERIFY, 12'h123, v);
    chk("R3 plain readback", v, 8'hA5);
    c0 = n_code;
    do_write(PIN_PCODE, 12'h124, 8'h11, 24);
    chk("R2 24 pulses no write", n_code - c0, 0);
    read_at(PIN_VERIFY, 12'h124, v);
    chk("R2 24 pulses data unchanged", v, 8'hFF);
  endtask

  task automatic t_idle_code();
    logic [7:0] v;
    int c0 = n_code + n_key + n_l1 + n_l2;
    do_write(6'b00_1011, 12'h130, 8'h00, 25);
    chk("R1 bad enable no write", n_code + n_key + n_l1 + n_l2 - c0, 0);
    read_at(PIN_IDLE, 12'h123, v);
    chk("R1 idle dout FF", v, 8'hFF);
    read_at(PIN_VERIFY, 12'h130, v);
    chk("R1 bad enable data unchanged", v, 8'hFF);
  endtask

  task automatic t_signature();
    logic [7:0] v;
    read_at(PIN_SIG, 12'h030, v); chk("R6 sig 030", v, 8'h89);
    read_at(PIN_SIG, 12'h031, v); chk("R6 sig 031", v, 8'h57);
    read_at(PIN_SIG, 12'h032, v); chk("R6 sig other", v, 8'hFF);
  endtask

  task automatic t_keys();
    logic [7:0] v;
    int k0 = n_key;
    do_write(PIN_PKEY, 12'h003, 8'h0F, 25);
    chk("R5 key_we in range", n_key - k0, 1);
    read_at(PIN_VERIFY, 12'h123, v);
    chk("R3 scrambled readback", v, 8'h55);
    read_at(PIN_VERIFY, 12'h200, v);
    chk("R4 erased key erased code", v, 8'hFF);
    k0 = n_key;
    do_write(PIN_PKEY, 12'h043, 8'h00, 25);
    chk("R5 key_we out of range", n_key - k0, 0);
    read_at(PIN_VERIFY, 12'h123, v);
    chk("R5 table unchanged", v, 8'h55);
  endtask

  task automatic t_mode_break();
    logic [7:0] v;
    int c0 = n_code;
    addr = 12'h155; din = 8'h3C;
    set_mode(PIN_PCODE);
    pulses(20);
    set_mode(PIN_IDLE);
    set_mode(PIN_PCODE);
    pulses(20);
    chk("R12 count cleared no write", n_code - c0, 0);
    pulses(5);
    set_mode(PIN_IDLE);
    chk("R12 write after fresh 25", n_code - c0, 1);
    read_at(PIN_VERIFY, 12'h155, v);
    chk("R12 data", v, 8'h3C);
  endtask

  task automatic t_reset_race();
    logic [7:0] v;
    int c0 = n_code;
    addr = 12'h166; din = 8'h77;
    set_mode(PIN_PCODE);
    pulses(24);
    @(negedge clk) prog_n = 1'b0;
    @(negedge clk) rst = 1'b1;
    @(negedge clk) begin rst = 1'b0; prog_n = 1'b1; end
    repeat (4) @(negedge clk);
    chk("R11 reset beats commit", n_code - c0, 0);
    pulses(1);
    chk("R11 count restarted", n_code - c0, 0);
    set_mode(PIN_IDLE);
    read_at(PIN_VERIFY, 12'h166, v);
    chk("R11 data unchanged", v, 8'hFF);
  endtask

  task automatic t_ea_unlocked();
    @(negedge clk) ea_pin = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 follows pin", ea_eff, 0);
    chk("R9 no deny unlocked", int_fetch_deny, 0);
    @(negedge clk) ea_pin = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 follows pin high", ea_eff, 1);
  endtask

  task automatic t_lock1();
    logic [7:0] v;
    int c0 = n_code, k0 = n_key, l0 = n_l1;
    do_write(PIN_PLK1, 12'h000, 8'h00, 25);
    chk("R7 lock1 set", n_l1 - l0, 1);
    do_write(PIN_PCODE, 12'h170, 8'h12, 25);
    chk("R7 code write blocked", n_code - c0, 0);
    read_at(PIN_VERIFY, 12'h170, v);
    chk("R7 code unchanged", v, 8'hFF);
    do_write(PIN_PKEY, 12'h003, 8'hF0, 25);
    chk("R7 key write blocked", n_key - k0, 0);
    read_at(PIN_VERIFY, 12'h123, v);
    chk("R8 lock1 alone verify ok", v, 8'h55);
  endtask

  task automatic t_ea_locked();
    ea_pin = 1'b1;
    pulse_reset();
    @(negedge clk) ea_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 latched high held", ea_eff, 1);
    chk("R9 no deny ea high", int_fetch_deny, 0);
    pulse_reset();
    @(negedge clk) ea_pin = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 latched low held", ea_eff, 0);
    chk("R9 deny with lock1", int_fetch_deny, 1);
  endtask

  task automatic t_lock2();
    logic [7:0] v;
    int l0 = n_l2;
    do_write(PIN_PLK2, 12'h000, 8'h00, 25);
    chk("R7 lock2 still settable", n_l2 - l0, 1);
    read_at(PIN_VERIFY, 12'h123, v);
    chk("R8 both locks verify FF", v, 8'hFF);
    read_at(PIN_SIG, 12'h030, v);
    chk("R8 signature unaffected", v, 8'h89);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_code_write();
    t_idle_code();
    t_signature();
    t_keys();
    t_mode_break();
    t_reset_race();
    t_ea_unlocked();
    t_lock1();
    t_ea_locked();
    t_lock2();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule